// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Controller

This block sits between instruction fetch and a single decode/execute port. It accepts one 32-bit fetched word at a time. The top two bits of the word pick how its 30-bit payload is read. The payload is either one long instruction or two packed 15-bit short instructions. A short pair runs right slot first, left slot first, or as a parallel pair. The block hands the slots out one at a time over a valid/ready port. After each slot it waits for a status response and then decides whether the partner slot may run.

Opcode lookup itself is outside the block. The controller drives two 6-bit lookup keys from the held word, one per slot, and reads back a hit flag and a "parallel-only conditional test" flag for each. A miss ends the word as an illegal-instruction fault, with the PC held. After the last slot of a word, or after a fault, a one-cycle completion pulse is raised. A bank of saturating event counters records issue statistics and can be read through a select input.

Top module: `dual_slot_issue`

## Requirements
- R1: `word_data[31:30]` selects the format: 2'b00 long, 2'b01 short pair right-first, 2'b10 short pair left-first, 2'b11 parallel pair. A long slot carries `word_data[29:0]` with `slot_tag`=0 and `slot_long`=1. The left short slot is `word_data[29:15]` with `slot_tag`=1. The right short slot is `word_data[14:0]` with `slot_tag`=2. Short slots are zero-extended to 30 bits with `slot_long`=0.
- R2: One clock after a word is accepted, `lk_key_a`=`word[29:24]`, `lk_key_b`=`word[14:9]`, and `lk_long` is 1 only for the long format. Hit/par-only for the long or left slot come from the `_a` inputs and for the right slot from the `_b` inputs. If the slot about to issue misses, it is not issued and the word ends with `done`, `done_exc` and `done_illegal` all 1. The illegal counter then increments.
- R3: In a right-first or left-first pair, the second slot is issued only if the first slot's response had `rsp_pc_chg`=0 and `rsp_exc`=0.
- R4: When the first slot of a right-first or left-first pair responds with `rsp_pc_chg`=1 and `rsp_exc`=0, the branch-skip counter increments and the word ends without a second slot.
- R5: In a parallel pair, a par-only left slot is the test slot. Otherwise a par-only right slot is the test slot. The test slot issues first. A response with `rsp_exc`=0 and `rsp_cond`=1 increments the cond-true counter and issues the partner. A response with `rsp_exc`=0 and `rsp_cond`=0 increments the cond-false counter and ends the word.
- R6: In a parallel pair with no test slot, the left slot issues and then the right slot, unless the left slot responded with `rsp_exc`=1. A parallel pair in which either slot misses issues nothing.
- R7: The cycle counter increments once per accepted word, and once more when the second slot of a right-first or left-first pair issues.
- R8: Each accepted word increments one format counter (long, left-first, right-first or parallel), whatever its lookup result.
- R9: `word_ready` is 1 only while no word is in progress. At most one slot is outstanding. While `slot_valid`=1 and `slot_ready`=0, the slot contents stay stable.
- R10: `done` is a one-cycle pulse. It is raised in the cycle after the edge that takes the final response, or the lookup miss. `done_exc` is 1 when that final response reported an exception or the word missed.
- R11: Counters reset to 0 and stop at all ones. `cnt_sel` reads them as follows: 0 cycles, 1 long, 2 left-first, 3 right-first, 4 parallel, 5 cond-true, 6 cond-false, 7 branch-skip, 8 illegal. Any other value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Fetched word offered |
| word_ready | output | 1 | Controller idle, word accepted on this edge if valid |
| word_data | input | 32 | Fetched instruction word |
| lk_key_a | output | 6 | Lookup key for long or left slot |
| lk_key_b | output | 6 | Lookup key for right slot |
| lk_long | output | 1 | Keys belong to a long instruction |
| lk_hit_a | input | 1 | Key A found |
| lk_hit_b | input | 1 | Key B found |
| lk_par_a | input | 1 | Slot A is a parallel-only conditional test |
| lk_par_b | input | 1 | Slot B is a parallel-only conditional test |
| slot_valid | output | 1 | Slot offered to decode |
| slot_ready | input | 1 | Decode takes the slot |
| slot_insn | output | 30 | Slot instruction bits |
| slot_tag | output | 2 | 0 long, 1 left, 2 right |
| slot_long | output | 1 | Slot is a long instruction |
| rsp_valid | input | 1 | Status for the outstanding slot |
| rsp_pc_chg | input | 1 | Slot changed the PC |
| rsp_exc | input | 1 | Slot raised an exception |
| rsp_cond | input | 1 | Condition result of a test slot |
| done | output | 1 | Word finished pulse |
| done_exc | output | 1 | Word ended on an exception |
| done_illegal | output | 1 | Word ended on a lookup miss, PC held |
| cnt_sel | input | 4 | Counter select |
| cnt_val | output | CNT_W | Selected counter value |

## Verification
The lookup keys are due one clock after the accepting edge. A lookup miss on the first slot raises `done` one clock later still. A slot appears one clock after the planning cycle or after the response that releases it. `done` follows the final response edge by one clock, and counters read back combinationally from `cnt_sel`. The bench drives at falling edges and samples at the next falling edge after the edge that should change an output. Its behavioural model predicts the ordered slot queue, the completion flags and all nine counters, and it compares them at each slot handshake, at each completion and after each word.

// File: rtl/dual_slot_issue.sv
module dual_slot_issue #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic [31:0]      word_data,
  output logic [5:0]       lk_key_a,
  output logic [5:0]       lk_key_b,
  output logic             lk_long,
  input  logic             lk_hit_a,
  input  logic             lk_hit_b,
  input  logic             lk_par_a,
  input  logic             lk_par_b,
  output logic             slot_valid,
  input  logic             slot_ready,
  output logic [29:0]      slot_insn,
  output logic [1:0]       slot_tag,
  output logic             slot_long,
  input  logic             rsp_valid,
  input  logic             rsp_pc_chg,
  input  logic             rsp_exc,
  input  logic             rsp_cond,
  output logic             done,
  output logic             done_exc,
  output logic             done_illegal,
  input  logic [3:0]       cnt_sel,
  output logic [CNT_W-1:0] cnt_val
);
  localparam int NCNT  = 9;
  localparam int SEL_W = 4;
  localparam int C_CYC = 0, C_LONG = 1, C_LF = 2, C_RF = 3, C_PAR = 4;
  localparam int C_TRUE = 5, C_FALSE = 6, C_SKIP = 7, C_ILL = 8;
  localparam logic [1:0] T_LONG = 2'd0, T_L = 2'd1, T_R = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_ISSUE, S_WAIT} st_t;
  typedef enum logic [1:0] {M_LONG, M_SEQ, M_PCOND, M_PPLAIN} md_t;

  st_t st, st_n;
  md_t md, md_n;
  logic [31:0] wrd;
  logic [1:0]  cur, cur_n, sec, sec_n;
  logic        ph, ph_n;
  logic        ld, fin, fexc, fill;
  logic [NCNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic        sec_hit;

  assign word_ready = (st == S_IDLE);
  assign lk_key_a   = wrd[29:24];
  assign lk_key_b   = wrd[14:9];
  assign lk_long    = (wrd[31:30] == 2'b00);
  assign slot_valid = (st == S_ISSUE);
  assign slot_tag   = cur;
  assign slot_long  = (cur == T_LONG);
  assign slot_insn  = (cur == T_LONG) ? wrd[29:0]
                    : {15'd0, (cur == T_L) ? wrd[29:15] : wrd[14:0]};
  assign sec_hit    = (sec == T_R) ? lk_hit_b : lk_hit_a;

  always_comb begin
    st_n = st; md_n = md; cur_n = cur; sec_n = sec; ph_n = ph;
    ld = 1'b0; fin = 1'b0; fexc = 1'b0; fill = 1'b0; inc = '0;
    case (st)
      S_IDLE: if (word_valid) begin
        ld = 1'b1;
        ph_n = 1'b0;
        inc[C_CYC] = 1'b1;
        case (word_data[31:30])
          2'b00:   inc[C_LONG] = 1'b1;
          2'b10:   inc[C_LF]   = 1'b1;
          2'b01:   inc[C_RF]   = 1'b1;
          default: inc[C_PAR]  = 1'b1;
        endcase
        st_n = S_PLAN;
      end
      S_PLAN: begin
        case (wrd[31:30])
          2'b00: begin
            md_n = M_LONG; cur_n = T_LONG; sec_n = T_LONG;
            if (lk_hit_a) st_n = S_ISSUE; else fill = 1'b1;
          end
          2'b01: begin
            md_n = M_SEQ; cur_n = T_R; sec_n = T_L;
            if (lk_hit_b) st_n = S_ISSUE; else fill = 1'b1;
          end
          2'b10: begin
            md_n = M_SEQ; cur_n = T_L; sec_n = T_R;
            if (lk_hit_a) st_n = S_ISSUE; else fill = 1'b1;
          end
          default: begin
            if (!(lk_hit_a && lk_hit_b)) fill = 1'b1;
            else begin
              st_n = S_ISSUE;
              if (lk_par_a) begin
                md_n = M_PCOND; cur_n = T_L; sec_n = T_R;
              end else if (lk_par_b) begin
                md_n = M_PCOND; cur_n = T_R; sec_n = T_L;
              end else begin
                md_n = M_PPLAIN; cur_n = T_L; sec_n = T_R;
              end
            end
          end
        endcase
      end
      S_ISSUE: if (slot_ready) st_n = S_WAIT;
      S_WAIT: if (rsp_valid) begin
        if (ph || md == M_LONG || rsp_exc) begin
          fin = 1'b1; fexc = rsp_exc;
        end else begin
          case (md)
            M_SEQ: begin
              if (rsp_pc_chg) begin
                inc[C_SKIP] = 1'b1; fin = 1'b1;
              end else if (sec_hit) begin
                inc[C_CYC] = 1'b1; cur_n = sec; ph_n = 1'b1; st_n = S_ISSUE;
              end else fill = 1'b1;
            end
            M_PCOND: begin
              if (rsp_cond) begin
                inc[C_TRUE] = 1'b1; cur_n = sec; ph_n = 1'b1; st_n = S_ISSUE;
              end else begin
                inc[C_FALSE] = 1'b1; fin = 1'b1;
              end
            end
            default: begin
              cur_n = sec; ph_n = 1'b1; st_n = S_ISSUE;
            end
          endcase
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (fill) begin
      fin = 1'b1; fexc = 1'b1; inc[C_ILL] = 1'b1;
    end
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= M_LONG; wrd <= '0;
      cur <= T_LONG; sec <= T_LONG; ph <= 1'b0;
      done <= 1'b0; done_exc <= 1'b0; done_illegal <= 1'b0;
    end else begin
      st <= st_n; md <= md_n; cur <= cur_n; sec <= sec_n; ph <= ph_n;
      if (ld) wrd <= word_data;
      done <= fin; done_exc <= fexc; done_illegal <= fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++)
        if (inc[i] && cnt[i] != {CNT_W{1'b1}}) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  always_comb begin
    cnt_val = '0;
    for (int i = 0; i < NCNT; i++)
      if (cnt_sel == SEL_W'(i)) cnt_val = cnt[i];
  end
endmodule

// File: rtl/dual_slot_issue_chk.sv
module dual_slot_issue_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_ready,
  input logic             slot_valid,
  input logic             slot_ready,
  input logic [29:0]      slot_insn,
  input logic [1:0]       slot_tag,
  input logic             slot_long,
  input logic             rsp_valid,
  input logic             done,
  input logic             done_exc,
  input logic             done_illegal,
  input logic [3:0]       cnt_sel,
  input logic [CNT_W-1:0] cnt_val
);
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_ready |=> slot_valid && $stable(slot_insn) && $stable(slot_tag)); // R9
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> !word_ready); // R9
  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_long |-> slot_insn[29:15] == 15'd0); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_illegal |-> $past(rsp_valid)); // R10
  AST_ILL_IS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    done_illegal |-> done && done_exc); // R2
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cnt_sel) |-> cnt_val >= $past(cnt_val)); // R11
endmodule

bind dual_slot_issue dual_slot_issue_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .slot_valid(slot_valid),
  .slot_ready(slot_ready), .slot_insn(slot_insn), .slot_tag(slot_tag),
  .slot_long(slot_long), .rsp_valid(rsp_valid), .done(done),
  .done_exc(done_exc), .done_illegal(done_illegal), .cnt_sel(cnt_sel),
  .cnt_val(cnt_val)
);

// File: tb/dual_slot_issue_tb.sv
module dual_slot_issue_tb;
  localparam int W = 6;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_valid = 1'b0, word_ready;
  logic [31:0] word_data = '0;
  logic [5:0] lk_key_a, lk_key_b;
  logic lk_long;
  logic lk_hit_a = 1'b0, lk_hit_b = 1'b0, lk_par_a = 1'b0, lk_par_b = 1'b0;
  logic slot_valid, slot_ready = 1'b0, slot_long;
  logic [29:0] slot_insn;
  logic [1:0] slot_tag;
  logic rsp_valid = 1'b0, rsp_pc_chg = 1'b0, rsp_exc = 1'b0, rsp_cond = 1'b0;
  logic done, done_exc, done_illegal;
  logic [3:0] cnt_sel = '0;
  logic [W-1:0] cnt_val;

  int tests = 0, fails = 0;
  int mc [9];
  int q [$];
  bit x_exc, x_ill;

  always #5 clk = ~clk;

  dual_slot_issue #(.CNT_W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void bump(input int i);
    if (mc[i] < MAXC) mc[i]++;
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0: return "R7";
      1, 2, 3, 4: return "R8";
      5, 6: return "R5";
      7: return "R4";
      8: return "R2";
      default: return "R11";
    endcase
  endfunction

  // Behavioural model: slot order, completion flags, counter increments.
  task automatic model(input [31:0] w, input bit ha, hb, pa, pb,
                       input [2:0] pcm, exm, cdm);
    logic [1:0] f;
    int a, b;
    bit ill;
    q.delete(); x_exc = 0; ill = 0;
    f = w[31:30];
    bump(0);
    bump(f == 2'b00 ? 1 : f == 2'b10 ? 2 : f == 2'b01 ? 3 : 4);
    if (f == 2'b00) begin
      if (!ha) ill = 1; else begin q.push_back(0); x_exc = exm[0]; end
    end else if (f != 2'b11) begin
      a = (f == 2'b10) ? 1 : 2; b = 3 - a;
      if (!((a == 1) ? ha : hb)) ill = 1;
      else begin
        q.push_back(a);
        if (exm[a]) x_exc = 1;
        else if (pcm[a]) bump(7);
        else if (!((b == 1) ? ha : hb)) ill = 1;
        else begin bump(0); q.push_back(b); x_exc = exm[b]; end
      end
    end else begin
      if (!(ha && hb)) ill = 1;
      else if (pa || pb) begin
        a = pa ? 1 : 2; b = 3 - a;
        q.push_back(a);
        if (exm[a]) x_exc = 1;
        else if (cdm[a]) begin bump(5); q.push_back(b); x_exc = exm[b]; end
        else bump(6);
      end else begin
        q.push_back(1);
        if (exm[1]) x_exc = 1;
        else begin q.push_back(2); x_exc = exm[2]; end
      end
    end
    if (ill) begin bump(8); x_exc = 1; end
    x_ill = ill;
  endtask

  function automatic logic [29:0] exp_insn(input [31:0] w, input int t);
    if (t == 0) return w[29:0];
    if (t == 1) return {15'd0, w[29:15]};
    return {15'd0, w[14:0]};
  endfunction

  task automatic check_counters();
    for (int i = 0; i < 10; i++) begin
      cnt_sel = 4'(i + (i == 9 ? 3 : 0));
      #1;
      if (i < 9) chk(cnt_val == W'(mc[i]), req_of(i), cnt_val, mc[i]);
      else chk(cnt_val == '0, "R11", cnt_val, 0);
    end
    cnt_sel = '0;
  endtask

  task automatic run_word(input [31:0] w, input bit ha, hb, pa, pb,
                          input [2:0] pcm, exm, cdm, input int stall);
    bit got;
    int t, g;
    logic [29:0] hold;
    model(w, ha, hb, pa, pb, pcm, exm, cdm);
    lk_hit_a = ha; lk_hit_b = hb; lk_par_a = pa; lk_par_b = pb;
    @(negedge clk);
    chk(word_ready == 1'b1, "R9", word_ready, 1);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
    chk(lk_key_a == w[29:24] && lk_key_b == w[14:9] && lk_long == (w[31:30] == 2'b00),
        "R2", {lk_long, lk_key_a, lk_key_b}, {(w[31:30] == 2'b00), w[29:24], w[14:9]});
    got = 0; g = 0;
    while (!got && g < 60) begin
      g++;
      if (done) begin
        got = 1;
        chk(done_exc == x_exc && done_illegal == x_ill, "R10",
            {done_exc, done_illegal}, {x_exc, x_ill});
        chk(q.size() == 0, "R3", q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10", done, 0);
      end else if (slot_valid) begin
        hold = slot_insn;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(slot_valid && slot_insn == hold, "R9", slot_insn, hold);
        end
        if (q.size() == 0) begin
          chk(1'b0, "R3", slot_tag, 3);
          t = slot_tag;
        end else begin
          t = q.pop_front();
          chk(slot_tag == 2'(t) && slot_long == (t == 0) && slot_insn == exp_insn(w, t),
              (w[31:30] == 2'b11) ? "R6" : "R1", {slot_tag, slot_insn}, {2'(t), exp_insn(w, t)});
        end
        chk(word_ready == 1'b0, "R9", word_ready, 0);
        slot_ready = 1'b1;
        @(negedge clk);
        slot_ready = 1'b0;
        rsp_valid = 1'b1; rsp_pc_chg = pcm[t]; rsp_exc = exm[t]; rsp_cond = cdm[t];
        @(negedge clk);
        rsp_valid = 1'b0; rsp_pc_chg = 1'b0; rsp_exc = 1'b0; rsp_cond = 1'b0;
      end else @(negedge clk);
    end
    chk(got, "R10", got, 1);
    check_counters();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) mc[i] = 0;
    repeat (3) @(negedge clk);
    chk(word_ready == 1'b1 && slot_valid == 1'b0 && done == 1'b0, "R11",
        {word_ready, slot_valid, done}, 3'b100);
    rst_n = 1'b1;
    check_counters();
    // R1 long hit, then R2 long miss
    run_word({2'b00, 30'h2ABC_1234}, 1, 0, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    run_word({2'b00, 30'h0F0F_0F0F}, 0, 1, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    // R3 right-first pair both issue, R7 extra cycle
    run_word({2'b01, 15'h5A5A, 15'h1234}, 1, 1, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    // R4 left-first, first slot branches
    run_word({2'b10, 15'h7001, 15'h0222}, 1, 1, 0, 0, 3'b010, 3'b000, 3'b000, 0);
    // R3 left-first, first slot exception (and branch): no skip count
    run_word({2'b10, 15'h3003, 15'h0444}, 1, 1, 0, 0, 3'b010, 3'b010, 3'b000, 0);
    // R2 sequential second slot misses
    run_word({2'b01, 15'h1111, 15'h6666}, 0, 1, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    // R6 parallel plain, then left exception
    run_word({2'b11, 15'h2468, 15'h1357}, 1, 1, 0, 0, 3'b110, 3'b000, 3'b000, 2);
    run_word({2'b11, 15'h2222, 15'h3333}, 1, 1, 0, 0, 3'b000, 3'b010, 3'b000, 0);
    // R6 parallel miss issues nothing
    run_word({2'b11, 15'h4444, 15'h5555}, 1, 0, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    // R5 left test true, right test false, both par -> left test
    run_word({2'b11, 15'h0ACE, 15'h0BDF}, 1, 1, 1, 0, 3'b000, 3'b000, 3'b010, 1);
    run_word({2'b11, 15'h0ACE, 15'h0BDF}, 1, 1, 0, 1, 3'b000, 3'b000, 3'b010, 0);
    run_word({2'b11, 15'h7777, 15'h0001}, 1, 1, 1, 1, 3'b000, 3'b000, 3'b100, 0);
    // R9 stalls on slot_ready with a long slot
    run_word({2'b00, 30'h1555_AAAA}, 1, 1, 0, 0, 3'b000, 3'b001, 3'b000, 3);
    // R11 saturation
    for (int k = 0; k < 30; k++)
      run_word({2'b01, 15'(k * 7), 15'(k * 13)}, 1, 1, 0, 0, 3'b000, 3'b000, 3'b000, 0);
    cnt_sel = 4'd0; #1;
    chk(cnt_val == W'(MAXC), "R11", cnt_val, MAXC);
    cnt_sel = 4'd0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule